// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide, two-address register front end of one programmable interrupt controller. Software writes a short setup sequence through it: a start word, a vector base, a skipped word and, optionally, a mode word. After that it writes runtime commands that load the line mask, move the rotation offset, pick a register for read-back, arm poll mode and retire in-service lines. The block holds the mask, the vector base, the rotation offset and the mode flags, and it drives them out to the priority resolver next to it.

The request and in-service registers themselves are held elsewhere. This block takes their values in for read-back. It also takes in, from the resolver, the highest-priority in-service line and the highest-priority pending line. When a command or a poll read retires a line, the block raises a one-hot clear pulse in the same cycle as the strobe. Register and flag updates show up on the clock edge that ends the strobe cycle. Read data is combinational while the read strobe is high. Interrupt acknowledge cycles and cascading are outside this block.

Top module: `pic_cmd_decoder`

## Requirements
- R1: Reset clears the mask, vector base, rotation offset and all flags (special fully nested, auto end-of-interrupt, rotate on auto end-of-interrupt, special mask, poll, read-select). It also returns the setup sequence to normal operation.
- R2: A write to address 0 with data bit 4 set starts setup. It stores "mode word needed" from bit 0 and clears the mask, the offset, special mask and read-select. If bit 0 is 0, it also clears special fully nested and auto end-of-interrupt. The next address-1 write is then taken as the base word.
- R3: The first address-1 write after a start word sets the vector base to data AND 0xF8.
- R4: The second address-1 write changes no register. Setup then returns to normal, unless the mode word is needed. In that case the third address-1 write sets special fully nested from bit 4 and auto end-of-interrupt from bit 1, and setup returns to normal.
- R5: In normal operation an address-1 write loads the mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 = 1 arms poll. Bit 1 = 1 loads read-select from bit 0. Bit 6 = 1 loads special mask from bit 5.
- R7: An address-0 write with bits 4 and 3 clear decodes bits 7:5 as a command. Commands 0 and 4 set rotate-on-auto-end-of-interrupt to data bit 7. Command 2 changes nothing.
- R8: Commands 1 and 5 retire the in-service line reported by the resolver: a one-hot pulse on isr_clr at that line's bit, in the write cycle. Command 5 also sets the offset to (line+1) mod 8. When no line is in service, neither command has any effect.
- R9: Commands 3 and 7 pulse isr_clr at line data[2:0]. Command 7 also sets the offset to (line+1) mod 8.
- R10: Command 6 sets the offset to (data[2:0]+1) mod 8 and clears nothing.
- R11: With poll disarmed, an address-1 read returns the mask. An address-0 read returns the in-service input if read-select is 1 and the request input if it is 0. rdata is 0 when no read is in progress.
- R12: With poll armed, a read at either address returns the pending line from the resolver. It also pulses the same one-hot bit on both isr_clr and irr_clr. If no line is pending, the read returns 7 and pulses nothing. Poll is disarmed after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irr_in | input | LINES | Request register for read-back |
| isr_in | input | LINES | In-service register for read-back |
| svc_valid | input | 1 | Some line is in service |
| svc_line | input | LW | Highest-priority in-service line |
| poll_valid | input | 1 | Some unmasked line is pending and wins |
| poll_line | input | LW | Winning pending line |
| isr_clr | output | LINES | One-hot in-service clear pulse |
| irr_clr | output | LINES | One-hot request clear pulse |
| mask | output | LINES | Line mask |
| vec_base | output | 8 | Vector base |
| rot_ofs | output | LW | Rotation offset |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Auto end-of-interrupt |
| rot_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| poll_mode | output | 1 | Poll armed |

## Verification
The assertions check on every cycle that the clear pulses are one-hot and that both clear pulses agree. They also check that a start word zeroes the mask and offset, that the base and mask take their write data in the correct setup step, that command 6 gives the incremented offset, and that poll disarms after a read. Some behaviours can only be shown by the bench's directed and random scenarios: the skipped second word, the optional mode word, the no-effect case of a non-specific end-of-interrupt with nothing in service, read-select steering, and the value 7 returned by an empty poll.

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr_in,
  input  logic             svc_valid,
  input  logic [LW-1:0]    svc_line,
  input  logic             poll_valid,
  input  logic [LW-1:0]    poll_line,
  output logic [LINES-1:0] isr_clr,
  output logic [LINES-1:0] irr_clr,
  output logic [LINES-1:0] mask,
  output logic [7:0]       vec_base,
  output logic [LW-1:0]    rot_ofs,
  output logic             sfnm,
  output logic             aeoi,
  output logic             rot_aeoi,
  output logic             spec_mask,
  output logic             poll_mode
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_SKIP, ST_MODE} step_t;
  localparam logic [7:0] BASE_KEEP = 8'hFF << LW;

  step_t step;
  logic  need_mode, rd_sel;

  logic       wr0, wr1, start_w, ctrl_w, cmd_w;
  logic [2:0] cmd;
  logic       eoi_ns, eoi_sp, poll_hit;

  assign wr0     = wr_en & ~addr;
  assign wr1     = wr_en & addr;
  assign start_w = wr0 & wdata[4];
  assign ctrl_w  = wr0 & ~wdata[4] & wdata[3];
  assign cmd_w   = wr0 & ~wdata[4] & ~wdata[3];
  assign cmd     = wdata[7:5];

  assign eoi_ns   = cmd_w & (cmd == 3'd1 || cmd == 3'd5) & svc_valid;
  assign eoi_sp   = cmd_w & (cmd == 3'd3 || cmd == 3'd7);
  assign poll_hit = rd_en & poll_mode & poll_valid;

  always_comb begin
    isr_clr = '0;
    irr_clr = '0;
    if (eoi_ns)
      isr_clr[svc_line] = 1'b1;
    else if (eoi_sp)
      isr_clr[wdata[LW-1:0]] = 1'b1;
    else if (poll_hit) begin
      isr_clr[poll_line] = 1'b1;
      irr_clr[poll_line] = 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (poll_mode)
        rdata = poll_valid ? 8'(poll_line) : 8'd7;
      else if (addr)
        rdata = 8'(mask);
      else
        rdata = rd_sel ? 8'(isr_in) : 8'(irr_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= ST_RUN;
      need_mode <= 1'b0;
      rd_sel    <= 1'b0;
      mask      <= '0;
      vec_base  <= '0;
      rot_ofs   <= '0;
      sfnm      <= 1'b0;
      aeoi      <= 1'b0;
      rot_aeoi  <= 1'b0;
      spec_mask <= 1'b0;
      poll_mode <= 1'b0;
    end else begin
      if (rd_en && poll_mode)
        poll_mode <= 1'b0;
      if (start_w) begin
        need_mode <= wdata[0];
        mask      <= '0;
        rot_ofs   <= '0;
        spec_mask <= 1'b0;
        rd_sel    <= 1'b0;
        if (!wdata[0]) begin
          sfnm <= 1'b0;
          aeoi <= 1'b0;
        end
        step <= ST_BASE;
      end else if (ctrl_w) begin
        if (wdata[2]) poll_mode <= 1'b1;
        if (wdata[1]) rd_sel    <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end else if (cmd_w) begin
        case (cmd)
          3'd0, 3'd4: rot_aeoi <= wdata[7];
          3'd5: if (svc_valid) rot_ofs <= svc_line + 1'b1;
          3'd6, 3'd7: rot_ofs <= wdata[LW-1:0] + 1'b1;
          default: ;
        endcase
      end else if (wr1) begin
        case (step)
          ST_RUN:  mask <= wdata[LINES-1:0];
          ST_BASE: begin
            vec_base <= wdata & BASE_KEEP;
            step     <= ST_SKIP;
          end
          ST_SKIP: step <= need_mode ? ST_MODE : ST_RUN;
          default: begin
            sfnm <= wdata[4];
            aeoi <= wdata[1];
            step <= ST_RUN;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_cmd_decoder_sva.sv
module pic_cmd_decoder_sva #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       wdata,
  input logic [1:0]       step,
  input logic [LINES-1:0] mask,
  input logic [7:0]       vec_base,
  input logic [LW-1:0]    rot_ofs,
  input logic             spec_mask,
  input logic             poll_mode,
  input logic [LINES-1:0] isr_clr,
  input logic [LINES-1:0] irr_clr
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (mask == '0 && vec_base == 8'd0 && rot_ofs == '0 && !poll_mode));

  assert_start_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask == '0 && rot_ofs == '0 && !spec_mask));

  assert_base_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && step == 2'd1) |=> (vec_base == ($past(wdata) & (8'hFF << LW))));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && step == 2'd0) |=> (mask == $past(wdata[LINES-1:0])));

  assert_clear_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr) && $onehot0(irr_clr));

  assert_set_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b11000) |=> (rot_ofs == LW'($past(wdata[LW-1:0]) + 1'b1)));

  assert_poll_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_mode && !wr_en) |=> !poll_mode);

  assert_poll_pair_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_clr != '0) |-> (irr_clr == isr_clr && rd_en));
endmodule

bind pic_cmd_decoder pic_cmd_decoder_sva #(.LINES(LINES)) u_sva (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .step(step), .mask(mask), .vec_base(vec_base),
  .rot_ofs(rot_ofs), .spec_mask(spec_mask), .poll_mode(poll_mode),
  .isr_clr(isr_clr), .irr_clr(irr_clr)
);

// File: tb/pic_cmd_decoder_test.sv
`timescale 1ns/1ps
module pic_cmd_decoder_test;
  logic       clk = 0, rst_n = 0, addr = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, irr_in = 0, isr_in = 0, mask, vec_base;
  logic       svc_valid = 0, poll_valid = 0;
  logic [2:0] svc_line = 0, poll_line = 0, rot_ofs;
  logic [7:0] isr_clr, irr_clr;
  logic       sfnm, aeoi, rot_aeoi, spec_mask, poll_mode;

  pic_cmd_decoder uut (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_mask, m_base;
  logic [2:0] m_ofs;
  logic m_need, m_sfnm, m_aeoi, m_rot, m_smm, m_rsel, m_poll;
  int m_step;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit a, input bit w, input bit r, input logic [7:0] d);
    if (r) return m_poll ? "R12" : "R11";
    if (!w) return "R1";
    if (a) return (m_step == 0) ? "R5" : (m_step == 1) ? "R3" : "R4";
    if (d[4]) return "R2";
    if (d[3]) return "R6";
    case (d[7:5])
      3'd1, 3'd5: return "R8";
      3'd3, 3'd7: return "R9";
      3'd6: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic model_reset();
    m_mask = 0; m_base = 0; m_ofs = 0; m_need = 0; m_sfnm = 0; m_aeoi = 0;
    m_rot = 0; m_smm = 0; m_rsel = 0; m_poll = 0; m_step = 0;
  endtask

  task automatic check_regs(input string tag);
    chk(tag, "mask", mask, m_mask);
    chk(tag, "base", vec_base, m_base);
    chk(tag, "offset", {5'd0, rot_ofs}, {5'd0, m_ofs});
    chk(tag, "flags", {3'd0, sfnm, aeoi, rot_aeoi, spec_mask, poll_mode},
        {3'd0, m_sfnm, m_aeoi, m_rot, m_smm, m_poll});
  endtask

  task automatic op(input bit a, input bit w, input bit r, input logic [7:0] d);
    string tag;
    logic [7:0] e_isr, e_irr, e_rd;
    tag = tag_of(a, w, r, d);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    e_isr = 0; e_irr = 0; e_rd = 0;
    if (w && !a && !d[4] && !d[3]) begin
      if ((d[7:5] == 1 || d[7:5] == 5) && svc_valid) e_isr = 8'd1 << svc_line;
      if (d[7:5] == 3 || d[7:5] == 7) e_isr = 8'd1 << d[2:0];
    end
    if (r && m_poll && poll_valid) begin
      e_isr = 8'd1 << poll_line; e_irr = e_isr;
    end
    if (r) e_rd = m_poll ? (poll_valid ? {5'd0, poll_line} : 8'd7)
                         : a ? m_mask : (m_rsel ? isr_in : irr_in);
    #1;
    chk(tag, "rdata", rdata, e_rd);
    chk(tag, "isr_clr", isr_clr, e_isr);
    chk(tag, "irr_clr", irr_clr, e_irr);
    @(posedge clk);
    if (r && m_poll) m_poll = 0;
    if (w && !a && d[4]) begin
      m_need = d[0]; m_mask = 0; m_ofs = 0; m_smm = 0; m_rsel = 0;
      if (!d[0]) begin m_sfnm = 0; m_aeoi = 0; end
      m_step = 1;
    end else if (w && !a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (w && !a) begin
      case (d[7:5])
        3'd0, 3'd4: m_rot = d[7];
        3'd5: if (svc_valid) m_ofs = svc_line + 3'd1;
        3'd6, 3'd7: m_ofs = d[2:0] + 3'd1;
        default: ;
      endcase
    end else if (w && a) begin
      case (m_step)
        0: m_mask = d;
        1: begin m_base = d & 8'hF8; m_step = 2; end
        2: m_step = m_need ? 3 : 0;
        default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_step = 0; end
      endcase
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check_regs(tag);
  endtask

  task automatic resolver(input bit sv, input logic [2:0] sl, input bit pv, input logic [2:0] pl);
    svc_valid = sv; svc_line = sl; poll_valid = pv; poll_line = pl;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED1234);
    model_reset();
    repeat (3) @(negedge clk);
    check_regs("R1");
    rst_n = 1;
    @(negedge clk);
    check_regs("R1");

    // R5 mask load, R11 readback
    op(1, 1, 0, 8'hA5);
    op(1, 0, 1, 8'h00);
    irr_in = 8'h3C; isr_in = 8'hC1;
    op(0, 0, 1, 8'h00);
    // R6 select in-service readback and special mask
    op(0, 1, 0, 8'h6B);
    op(0, 0, 1, 8'h00);
    // R2 start with mode word, R3 base, R4 skip then mode word
    op(0, 1, 0, 8'h11);
    op(1, 1, 0, 8'h47);
    op(1, 1, 0, 8'h5A);
    op(1, 1, 0, 8'h12);
    op(1, 1, 0, 8'h0F);
    // R2 start without mode word clears sfnm/aeoi
    op(0, 1, 0, 8'h10);
    op(1, 1, 0, 8'h88);
    op(1, 1, 0, 8'hFF);
    op(1, 1, 0, 8'h33);
    // R7 rotate flag, R7 no-op command 2
    op(0, 1, 0, 8'h80);
    op(0, 1, 0, 8'h40);
    op(0, 1, 0, 8'h00);
    // R8 non-specific EOI with nothing in service, then with line 6
    resolver(0, 3'd4, 0, 3'd0);
    op(0, 1, 0, 8'hA0);
    resolver(1, 3'd6, 0, 3'd0);
    op(0, 1, 0, 8'hA0);
    op(0, 1, 0, 8'h20);
    // R9 specific EOI, R10 set offset
    op(0, 1, 0, 8'h65);
    op(0, 1, 0, 8'hE7);
    op(0, 1, 0, 8'hC2);
    // R12 poll with pending line, then empty poll
    resolver(0, 3'd0, 1, 3'd3);
    op(0, 1, 0, 8'h0C);
    op(1, 0, 1, 8'h00);
    op(1, 0, 1, 8'h00);
    resolver(0, 3'd0, 0, 3'd5);
    op(0, 1, 0, 8'h0C);
    op(0, 0, 1, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [7:0] d;
      resolver($urandom % 2, 3'($urandom), $urandom % 2, 3'($urandom));
      irr_in = 8'($urandom); isr_in = 8'($urandom);
      d = 8'($urandom);
      kind = $urandom % 7;
      case (kind)
        0: op(0, 1, 0, d | 8'h10);
        1, 2: op(1, 1, 0, d);
        3: op(0, 1, 0, (d & 8'hEF) | 8'h08);
        4: op(0, 1, 0, d & 8'hE7);
        5: op(1'($urandom), 0, 1, 8'h00);
        default: op(1'($urandom), 0, 0, 8'h00);
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule